// File: doc/BRIEF.md
# Memory Traffic Statistics Gatherer

This block sits next to a memory arbiter and watches the grant it issues each cycle. It keeps two event counters and one counter of elapsed memory clocks. Each event counter has its own control word. The control word picks the kind of arbitration event to count and can limit counting to one requesting client. It can also limit counting by the state of one of the three grant priority flags: high-priority, timeout or bandwidth.

Software writes the control words and the clock limit over a small register bus. It then enables collection for a sampling window, disables it and reads the counts back. Some events depend on grant history: a repeat win by the same client, or a switch between read and write. For these the block remembers the previous grant it saw while enabled. A reset or clear command drops that memory together with the counts.

Top module: `mem_stat_gatherer`

## Requirements
- R1: After the synchronous reset `rst` the clock counter and both event counters are zero, the clock limit is all ones, collection is disabled and `reg_rdata` is zero.
- R2: A write to the command register (address 0) acts on `reg_wdata[9:8]` as follows. Value 0 zeroes all counters and the grant history and disables collection. Value 1 zeroes all counters and the grant history and leaves the enable state unchanged. Value 2 disables collection and value 3 enables it. Reading address 0 returns 0x300 when enabled and 0x200 when disabled.
- R3: Channel control words are at addresses 3 and 4. Their fields are: client ID in bits 13:8, event select in bits 23:16, flag select in bits 25:24, client-filter enable in bit 26 and flag-filter mode in bits 29:28. All other bits read back as zero, so a word reads back as the written value AND 0x37FF3F00.
- R4: Each event select value counts grants of one kind: 0 any grant, 1 read (`gnt_write`=0), 2 write, 3 direction change, 4 successive win, 5 `gnt_bank_a`, 6 `gnt_bank_b`, 7 `gnt_page_miss`, 8 `gnt_auto_pre`. Values 9 and above never count. A counter rises by at most one per cycle.
- R5: Flag select 0, 1 and 2 examines `gnt_hp`, `gnt_tmo` and `gnt_bw` respectively; select 3 examines a constant 0. Filter mode 1 counts only when the flag is clear and mode 2 only when it is set. Modes 0 and 3 ignore the flag.
- R6: With the client filter enabled, a channel counts only grants whose `gnt_client` equals the control word's client ID. With it disabled, grants from every client count.
- R7: A successive event fires when the granted client equals the client of the previous grant seen since the last reset or clear. N back-to-back wins by one client therefore add N-1.
- R8: A direction-change event fires when a grant's read/write direction differs from that of the previous grant seen since the last reset or clear.
- R9: While enabled, the clock counter (address 2) increments every cycle while it is below the limit register (address 1), and it then stays put.
- R10: Event counters are CNT_W bits wide and saturate at all ones instead of wrapping.
- R11: While disabled, counters and grant history hold their values and stay readable.
- R12: `reg_rdata` shows the register addressed by `reg_addr` one cycle later. Event counters are at addresses 5 and 6. Writes to addresses 2, 5, 6 and 7 have no effect. In a cycle with a write, counting uses the settings that were in place before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| gnt_valid | input | 1 | A grant is issued this cycle |
| gnt_client | input | 6 | ID of the granted client |
| gnt_write | input | 1 | Granted request is a write |
| gnt_hp | input | 1 | High-priority flag of the grant |
| gnt_tmo | input | 1 | Timeout flag of the grant |
| gnt_bw | input | 1 | Bandwidth flag of the grant |
| gnt_page_miss | input | 1 | Grant caused a page miss |
| gnt_auto_pre | input | 1 | Grant used auto-precharge |
| gnt_bank_a | input | 1 | First bank-arbitration event flag |
| gnt_bank_b | input | 1 | Second bank-arbitration event flag |

## Verification
A corrupted grant history is only visible through the successive and direction-change counts. It surfaces at the first grant after the fault, one cycle later on the read port. Such faults are caught by comparing every read cycle against a behavioural model that keeps its own previous-grant record. A stuck enable or a broken clear shows up as counts that drift during a window that should be quiet, or that are nonzero right after the clear. A wrong saturation or clock-limit compare needs long windows, so the bench uses an 8-bit counter width to reach the limits within a few hundred cycles.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int CLIENT_W = 6;
  localparam int NUM_CH   = 2;

  localparam logic [ADDR_W-1:0] ADDR_CMD   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLK   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTL0  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CNT0  = 3'd5;

  localparam logic [DATA_W-1:0] CTL_MASK = 32'h37FF_3F00;

  typedef enum logic [1:0] {
    CMD_RESET   = 2'd0,
    CMD_CLEAR   = 2'd1,
    CMD_DISABLE = 2'd2,
    CMD_ENABLE  = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [1:0]          flt_mode;
    logic                client_en;
    logic [1:0]          flag_sel;
    logic [7:0]          ev_sel;
    logic [CLIENT_W-1:0] client;
  } chan_cfg_t;

  typedef struct packed {
    logic                valid;
    logic [CLIENT_W-1:0] client;
    logic                write;
    logic                hp;
    logic                tmo;
    logic                bw;
    logic                page_miss;
    logic                auto_pre;
    logic                bank_a;
    logic                bank_b;
  } grant_t;

  function automatic chan_cfg_t decode_cfg(input logic [DATA_W-1:0] w);
    chan_cfg_t c;
    c.client    = w[13:8];
    c.ev_sel    = w[23:16];
    c.flag_sel  = w[25:24];
    c.client_en = w[26];
    c.flt_mode  = w[29:28];
    return c;
  endfunction
endpackage

// File: rtl/mstat_history.sv
module mstat_history
  import mstat_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                clr,
  input  logic                gnt_valid,
  input  logic [CLIENT_W-1:0] gnt_client,
  input  logic                gnt_write,
  output logic                succ,
  output logic                dir_chg
);
  logic                prev_valid;
  logic [CLIENT_W-1:0] prev_client;
  logic                prev_write;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_valid  <= 1'b0;
      prev_client <= '0;
      prev_write  <= 1'b0;
    end else if (en && gnt_valid) begin
      prev_valid  <= 1'b1;
      prev_client <= gnt_client;
      prev_write  <= gnt_write;
    end
  end

  assign succ    = gnt_valid && prev_valid && (gnt_client == prev_client);
  assign dir_chg = gnt_valid && prev_valid && (gnt_write != prev_write);

  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> ($stable(prev_valid) && $stable(prev_client) && $stable(prev_write))); // R11
  AST_HIST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> !prev_valid); // R7
endmodule

// File: rtl/mstat_channel.sv
module mstat_channel
  import mstat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  chan_cfg_t        cfg,
  input  grant_t           gnt,
  input  logic             succ,
  input  logic             dir_chg,
  output logic [CNT_W-1:0] count
);
  logic ev_hit, flag, flag_ok, client_ok, hit;

  always_comb begin
    unique case (cfg.ev_sel)
      8'd0:    ev_hit = gnt.valid;
      8'd1:    ev_hit = gnt.valid && !gnt.write;
      8'd2:    ev_hit = gnt.valid && gnt.write;
      8'd3:    ev_hit = dir_chg;
      8'd4:    ev_hit = succ;
      8'd5:    ev_hit = gnt.valid && gnt.bank_a;
      8'd6:    ev_hit = gnt.valid && gnt.bank_b;
      8'd7:    ev_hit = gnt.valid && gnt.page_miss;
      8'd8:    ev_hit = gnt.valid && gnt.auto_pre;
      default: ev_hit = 1'b0;
    endcase
    unique case (cfg.flag_sel)
      2'd0:    flag = gnt.hp;
      2'd1:    flag = gnt.tmo;
      2'd2:    flag = gnt.bw;
      default: flag = 1'b0;
    endcase
    unique case (cfg.flt_mode)
      2'd1:    flag_ok = !flag;
      2'd2:    flag_ok = flag;
      default: flag_ok = 1'b1;
    endcase
    client_ok = !cfg.client_en || (gnt.client == cfg.client);
    hit       = en && ev_hit && flag_ok && client_ok;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (hit && (count != '1))
      count <= count + 1'b1;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0)); // R2
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    ((count == '1) && !clr) |=> (count == '1)); // R10
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(count)); // R11
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((count == $past(count)) || (count == $past(count) + 1'b1))); // R4
  AST_CNT_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (!gnt.valid && !clr) |=> $stable(count)); // R4
endmodule

// File: rtl/mstat_clock_counter.sv
module mstat_clock_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (en && (count < limit))
      count <= count + 1'b1;
  end

  AST_CLK_STOP: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && (count >= limit)) |=> $stable(count)); // R9
  AST_CLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(count)); // R11
endmodule

// File: rtl/mem_stat_gatherer.sv
module mem_stat_gatherer
  import mstat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                gnt_valid,
  input  logic [CLIENT_W-1:0] gnt_client,
  input  logic                gnt_write,
  input  logic                gnt_hp,
  input  logic                gnt_tmo,
  input  logic                gnt_bw,
  input  logic                gnt_page_miss,
  input  logic                gnt_auto_pre,
  input  logic                gnt_bank_a,
  input  logic                gnt_bank_b
);
  logic             en_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] clk_cnt;
  logic             cmd_wr, clr;
  cmd_e             cmd;
  grant_t           gnt;
  logic             succ, dir_chg;
  logic [DATA_W-1:0] ctl_word [NUM_CH];
  logic [CNT_W-1:0]  ev_cnt   [NUM_CH];
  logic [DATA_W-1:0] rd_mux;

  assign gnt = '{valid: gnt_valid, client: gnt_client, write: gnt_write,
                 hp: gnt_hp, tmo: gnt_tmo, bw: gnt_bw,
                 page_miss: gnt_page_miss, auto_pre: gnt_auto_pre,
                 bank_a: gnt_bank_a, bank_b: gnt_bank_b};

  assign cmd_wr = reg_we && (reg_addr == ADDR_CMD);
  assign cmd    = cmd_e'(reg_wdata[9:8]);
  assign clr    = cmd_wr && ((cmd == CMD_RESET) || (cmd == CMD_CLEAR));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      limit_q <= '1;
    end else begin
      if (cmd_wr) begin
        unique case (cmd)
          CMD_ENABLE: en_q <= 1'b1;
          CMD_CLEAR:  en_q <= en_q;
          default:    en_q <= 1'b0;
        endcase
      end
      if (reg_we && (reg_addr == ADDR_LIMIT))
        limit_q <= reg_wdata[CNT_W-1:0];
    end
  end

  mstat_history u_hist (
    .clk(clk), .rst(rst), .en(en_q), .clr(clr),
    .gnt_valid(gnt_valid), .gnt_client(gnt_client), .gnt_write(gnt_write),
    .succ(succ), .dir_chg(dir_chg)
  );

  mstat_clock_counter #(.CNT_W(CNT_W)) u_clk (
    .clk(clk), .rst(rst), .en(en_q), .clr(clr), .limit(limit_q), .count(clk_cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_CTL = ADDR_CTL0 + ADDR_W'(i);
    logic [DATA_W-1:0] ctl_q;

    always_ff @(posedge clk) begin
      if (rst)
        ctl_q <= '0;
      else if (reg_we && (reg_addr == MY_CTL))
        ctl_q <= reg_wdata & CTL_MASK;
    end
    assign ctl_word[i] = ctl_q;

    mstat_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .en(en_q), .clr(clr),
      .cfg(decode_cfg(ctl_q)), .gnt(gnt), .succ(succ), .dir_chg(dir_chg),
      .count(ev_cnt[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      ADDR_CMD:   rd_mux = {22'd0, 1'b1, en_q, 8'd0};
      ADDR_LIMIT: rd_mux = DATA_W'(limit_q);
      ADDR_CLK:   rd_mux = DATA_W'(clk_cnt);
      default:    rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == ADDR_CTL0 + ADDR_W'(i)) rd_mux = ctl_word[i];
      if (reg_addr == ADDR_CNT0 + ADDR_W'(i)) rd_mux = DATA_W'(ev_cnt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  AST_ENABLE_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (cmd == CMD_ENABLE)) |=> en_q); // R2
  AST_DISABLE_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && ((cmd == CMD_DISABLE) || (cmd == CMD_RESET))) |=> !en_q); // R2
  AST_LIMIT_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && (reg_addr == ADDR_LIMIT)) |=> $stable(limit_q)); // R12
endmodule

// File: tb/mem_stat_gatherer_tb.sv
`timescale 1ns/1ps
module mem_stat_gatherer_tb_top;
  localparam int CW   = 8;
  localparam longint MAXC = (64'd1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        gnt_valid = 0, gnt_write = 0, gnt_hp = 0, gnt_tmo = 0, gnt_bw = 0;
  logic        gnt_page_miss = 0, gnt_auto_pre = 0, gnt_bank_a = 0, gnt_bank_b = 0;
  logic [5:0]  gnt_client = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_stat_gatherer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gnt_valid(gnt_valid), .gnt_client(gnt_client), .gnt_write(gnt_write),
    .gnt_hp(gnt_hp), .gnt_tmo(gnt_tmo), .gnt_bw(gnt_bw),
    .gnt_page_miss(gnt_page_miss), .gnt_auto_pre(gnt_auto_pre),
    .gnt_bank_a(gnt_bank_a), .gnt_bank_b(gnt_bank_b)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit          m_en, m_pv, m_pw;
  int          m_pc;
  longint      m_cnt [2];
  longint      m_clk, m_lim;
  logic [31:0] m_ctl [2];
  logic [31:0] exp_rd;
  bit          exp_ok = 0;

  function automatic bit m_hit(input int ch);
    logic [31:0] w = m_ctl[ch];
    bit f, ev, fok;
    case (w[25:24]) 0: f = gnt_hp; 1: f = gnt_tmo; 2: f = gnt_bw; default: f = 0; endcase
    case (w[29:28]) 1: fok = !f; 2: fok = f; default: fok = 1; endcase
    case (int'(w[23:16]))
      0: ev = gnt_valid;
      1: ev = gnt_valid && !gnt_write;
      2: ev = gnt_valid && gnt_write;
      3: ev = gnt_valid && m_pv && (gnt_write != m_pw);
      4: ev = gnt_valid && m_pv && (int'(gnt_client) == m_pc);
      5: ev = gnt_valid && gnt_bank_a;
      6: ev = gnt_valid && gnt_bank_b;
      7: ev = gnt_valid && gnt_page_miss;
      8: ev = gnt_valid && gnt_auto_pre;
      default: ev = 0;
    endcase
    if (w[26] && (int'(gnt_client) != int'(w[13:8]))) ev = 0;
    return ev && fok;
  endfunction

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0: return m_en ? 32'h300 : 32'h200;
      1: return 32'(m_lim);
      2: return 32'(m_clk);
      3: return m_ctl[0];
      4: return m_ctl[1];
      5: return 32'(m_cnt[0]);
      6: return 32'(m_cnt[1]);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_pv = 0; m_pw = 0; m_pc = 0; m_clk = 0; m_lim = MAXC;
      m_cnt[0] = 0; m_cnt[1] = 0; m_ctl[0] = 0; m_ctl[1] = 0;
      exp_rd = 0;
    end else begin
      bit h0, h1;
      exp_rd = m_read(int'(reg_addr));
      if (m_en) begin
        h0 = m_hit(0); h1 = m_hit(1);
        if (h0 && m_cnt[0] < MAXC) m_cnt[0]++;
        if (h1 && m_cnt[1] < MAXC) m_cnt[1]++;
        if (m_clk < m_lim) m_clk++;
        if (gnt_valid) begin m_pv = 1; m_pc = int'(gnt_client); m_pw = gnt_write; end
      end
      if (reg_we) begin
        case (int'(reg_addr))
          0: begin
            if (reg_wdata[9:8] <= 2'd1) begin
              m_cnt[0] = 0; m_cnt[1] = 0; m_clk = 0; m_pv = 0; m_pw = 0; m_pc = 0;
            end
            if (reg_wdata[9:8] == 2'd0 || reg_wdata[9:8] == 2'd2) m_en = 0;
            if (reg_wdata[9:8] == 2'd3) m_en = 1;
          end
          1: m_lim = longint'(reg_wdata) & MAXC;
          3: m_ctl[0] = reg_wdata & 32'h37FF3F00;
          4: m_ctl[1] = reg_wdata & 32'h37FF3F00;
          default: ;
        endcase
      end
    end
    exp_ok = 1;
  end

  // Per-cycle comparison of the read port against the model (R12)
  always @(negedge clk) begin
    if (exp_ok && !done) check("R12 per-cycle read port", longint'(reg_rdata), longint'(exp_rd));
  end

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input int a, input longint exp);
    reg_addr = 3'(a);
    @(negedge clk);
    check(tag, longint'(reg_rdata), exp);
  endtask

  task automatic grant(input int c, input bit w, input bit hp = 0, input bit tmo = 0,
                       input bit pm = 0, input bit ap = 0, input bit ba = 0);
    gnt_valid = 1; gnt_client = 6'(c); gnt_write = w; gnt_hp = hp; gnt_tmo = tmo;
    gnt_page_miss = pm; gnt_auto_pre = ap; gnt_bank_a = ba; gnt_bw = 0; gnt_bank_b = 0;
    @(negedge clk);
    gnt_valid = 0; gnt_hp = 0; gnt_tmo = 0; gnt_page_miss = 0; gnt_auto_pre = 0; gnt_bank_a = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5.0);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    rd_chk("R1 command after reset", 0, 'h200);
    rd_chk("R1 limit after reset", 1, MAXC);
    rd_chk("R1 clock count after reset", 2, 0);
    rd_chk("R1 count0 after reset", 5, 0);
    // R3: field mask on control word
    wr(3, 32'hFFFF_FFFF);
    rd_chk("R3 control readback mask", 3, 'h37FF3F00);
    // R4/R7: any grant and successive wins
    wr(3, 32'h0000_0000);
    wr(4, 32'h0004_0000);
    rd_chk("R3 control readback", 4, 'h00040000);
    wr(0, 32'h300);
    rd_chk("R2 enabled state", 0, 'h300);
    for (int i = 0; i < 5; i++) grant(3, 0);
    wr(0, 32'h200);
    rd_chk("R4 any-grant count", 5, 5);
    rd_chk("R7 successive count N-1", 6, 4);
    // R2 clear keeps disabled; R8 direction change
    wr(0, 32'h100);
    rd_chk("R2 clear zeroes count", 5, 0);
    rd_chk("R2 clear keeps disabled", 0, 'h200);
    wr(3, 32'h0003_0000);
    wr(4, 32'h0001_0000);
    wr(0, 32'h300);
    grant(1, 0); grant(1, 1); grant(1, 1); grant(1, 0); grant(1, 0); grant(1, 1);
    wr(0, 32'h200);
    rd_chk("R8 direction changes", 5, 3);
    rd_chk("R4 read count", 6, 3);
    // R6 client filter, R5 flag filter set-mode on timeout
    wr(0, 32'h100);
    wr(3, 32'h0400_0500);
    wr(4, 32'h2102_0000);
    wr(0, 32'h300);
    grant(5, 1, 0, 1); grant(2, 1); grant(5, 0, 0, 1); grant(5, 1); grant(2, 1, 0, 1);
    wr(0, 32'h200);
    rd_chk("R6 client filter", 5, 3);
    rd_chk("R5 flag set filter", 6, 2);
    // R5 flag clear filter on high-priority, page miss; bank A event
    wr(0, 32'h100);
    wr(3, 32'h1007_0000);
    wr(4, 32'h0005_0000);
    wr(0, 32'h300);
    grant(0, 0, 1, 0, 1); grant(1, 0, 0, 0, 1); grant(2, 1, 0, 0, 0, 0, 1); grant(3, 0, 0, 0, 1, 0, 1);
    wr(0, 32'h200);
    rd_chk("R5 flag clear filter", 5, 2);
    rd_chk("R4 bank event", 6, 2);
    // R11 hold while disabled
    for (int i = 0; i < 4; i++) grant(4, 0, 0, 0, 1);
    rd_chk("R11 count held while disabled", 5, 2);
    reg_addr = 3'd2; @(negedge clk); v = longint'(reg_rdata);
    idle(5);
    rd_chk("R11 clock held while disabled", 2, v);
    // R4 unused select, auto-precharge; R12 write to counter ignored
    wr(0, 32'h100);
    wr(3, 32'h0009_0000);
    wr(4, 32'h0008_0000);
    wr(0, 32'h300);
    for (int i = 0; i < 3; i++) grant(i, 0, 0, 0, 0, 1);
    wr(0, 32'h200);
    rd_chk("R4 select 9 never counts", 5, 0);
    rd_chk("R4 auto-precharge count", 6, 3);
    wr(6, 32'h0000_0000);
    rd_chk("R12 counter write ignored", 6, 3);
    // R2 reset command, R9 clock limit
    wr(0, 32'h000);
    rd_chk("R2 reset command zeroes", 6, 0);
    rd_chk("R2 reset command disables", 0, 'h200);
    wr(1, 32'd10);
    rd_chk("R9 limit readback", 1, 10);
    wr(0, 32'h300);
    idle(30);
    wr(0, 32'h200);
    rd_chk("R9 clock stops at limit", 2, 10);
    // R10 saturation
    wr(0, 32'h100);
    wr(3, 32'h0000_0000);
    wr(0, 32'h300);
    for (int i = 0; i < 300; i++) grant(i % 3, 0);
    wr(0, 32'h200);
    rd_chk("R10 counter saturates", 5, MAXC);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule